// File: doc/BRIEF.md
# DMA Interrupt Event Register Bank

This block gathers interrupt events from the channels of a DMA engine and from its bus masters into a small register file. Software reads and acknowledges the events through that file, and the block raises one combined interrupt line. Channel logic reports each event as a one-cycle pulse. There are three per-channel event classes: end of transfer count, pending count and low fill level. Each class has a status word, a write-1-to-clear word and a write-1-to-set word. There are also two packed event words. One holds per-channel underflow and overflow. The other holds per-channel errors and bus-master errors. Each packed word has an enable mask, a masked view, a clear word and a set word.

For every bus master the block keeps the number of the channel that caused that master's most recent error. A free-channel word reports the lowest-numbered channel that is not enabled, together with the bitmap of enabled channels. The register port is a plain single-cycle write strobe with a combinational read of the addressed word.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset every status, raw, enable and master-record word reads zero, and `irq_o` is 0.
- R2: A pulse on bit c of `ev_term`, `ev_pend` or `ev_lowm` sets bit c of that class's status word. The status word is at word address 0, 3 or 6 respectively, and the bit is visible after the next rising clock edge.
- R3: Writing a 1 to bit c of a clear word clears bit c of the matching status or raw word. The clear words are at addresses 1, 4 and 7 for the three classes and 12 and 17 for the two raw words. Bits written as 0 are left unchanged.
- R4: Writing a 1 to bit c of a set word sets bit c of the matching status or raw word. The set words are at addresses 2, 5 and 8 for the three classes and 13 and 18 for the two raw words.
- R5: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: Raw word 0 (address 9) holds underflow of channel c in bit c and overflow of channel c in bit 16+c. Raw word 1 (address 14) holds the error of channel c in bit c and the error of master m in bit 16+m. Bits with no source read zero.
- R7: Each raw word has a read/write enable word one address above it (10, 15). It also has a read-only masked word two above it (11, 16) that reads the raw word AND the enable word.
- R8: Raw-word bits are cleared and set through their own clear and set words, independently of the per-class words.
- R9: The master record word (address 19) holds, for master m, a 4-bit field at bits 4m+3..4m. On each error pulse of master m, that field takes the value of `merr_chan` slice m. A later pulse overwrites an earlier one.
- R10: The free-channel word (address 20) reads the lowest channel c whose `ch_enabled` bit is 0 in bits 4:0, or NUM_CH when all channels are enabled. It reads `ch_enabled` in bits 31:16.
- R11: `irq_o` is the OR of all three class status words and both masked words. It follows them with one clock of delay.
- R12: Writes to the status, raw, masked, master-record and free-channel addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_term | input | NUM_CH | Transfer-count-reached pulses, one per channel |
| ev_pend | input | NUM_CH | Pending-count pulses, one per channel |
| ev_lowm | input | NUM_CH | Low-fill-level pulses, one per channel |
| ev_under | input | NUM_CH | Underflow pulses, one per channel |
| ev_over | input | NUM_CH | Overflow pulses, one per channel |
| ev_cherr | input | NUM_CH | Channel error pulses |
| ev_merr | input | NUM_MST | Bus-master error pulses |
| merr_chan | input | NUM_MST*4 | Channel that caused each master's error |
| ch_enabled | input | NUM_CH | Enabled-channel bitmap |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Each event class is swept with a single pulse on every channel in turn, which shows up any bit that is swapped or stuck and any mix-up between classes. Raw words get mirrored patterns, with underflow on channel c and overflow on channel 15-c, so a wrong half-word placement cannot pass. Clear writes hit a mix of set and unset bits, and in one cycle they collide with an event. The free-channel scan runs over every prefix of enabled channels plus scattered holes, which separates "lowest free" from "highest free" and covers the all-enabled case.

// File: rtl/dma_irq_bank_pkg.sv
package dma_irq_bank_pkg;

   localparam int ADDR_W = 5;
   localparam int DATA_W = 32;
   localparam int HALF   = 16;
   localparam int FREE_W = 5;

   typedef enum logic [ADDR_W-1:0] {
      A_TC_STAT = 5'd0,  A_TC_CLR = 5'd1,  A_TC_SET = 5'd2,
      A_PC_STAT = 5'd3,  A_PC_CLR = 5'd4,  A_PC_SET = 5'd5,
      A_LW_STAT = 5'd6,  A_LW_CLR = 5'd7,  A_LW_SET = 5'd8,
      A_R0_RAW  = 5'd9,  A_R0_EN  = 5'd10, A_R0_MSK = 5'd11,
      A_R0_CLR  = 5'd12, A_R0_SET = 5'd13,
      A_R1_RAW  = 5'd14, A_R1_EN  = 5'd15, A_R1_MSK = 5'd16,
      A_R1_CLR  = 5'd17, A_R1_SET = 5'd18,
      A_MERR    = 5'd19, A_FREE   = 5'd20
   } reg_addr_e;

   localparam int CLS_STRIDE = 3;
   localparam int RAW_BASE   = 9;
   localparam int RAW_STRIDE = 5;

   function automatic logic [DATA_W-1:0] low_ones(input int n);
      return (DATA_W'(1) << n) - DATA_W'(1);
   endfunction

endpackage

// File: rtl/irqb_flag_word.sv
module irqb_flag_word #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev_i,
   input  logic         clr_we_i,
   input  logic         set_we_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] keep_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] clr_bits;
   logic [W-1:0] set_bits;

   always_comb begin
      clr_bits = clr_we_i ? wdata_i : '0;
      set_bits = set_we_i ? wdata_i : '0;
   end

   // events and set writes are ORed in after the clear, so they win
   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= ((q_o & ~clr_bits) | set_bits | ev_i) & keep_i;
   end
endmodule

// File: rtl/irqb_free_scan.sv
module irqb_free_scan #(
   parameter int N  = 16,
   parameter int IW = 5
) (
   input  logic [N-1:0]  en_i,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = IW'(N);
      for (int i = N - 1; i >= 0; i--) begin
         if (!en_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/irqb_merr_rec.sv
module irqb_merr_rec #(
   parameter int NM = 3,
   parameter int FW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NM-1:0]   ev_i,
   input  logic [NM*FW-1:0] chan_i,
   output logic [NM*FW-1:0] info_o
);
   for (genvar m = 0; m < NM; m++) begin : g_mst
      logic [FW-1:0] fld;
      always_ff @(posedge clk) begin
         if (!rst_n)      fld <= '0;
         else if (ev_i[m]) fld <= chan_i[m*FW +: FW];
      end
      assign info_o[m*FW +: FW] = fld;
   end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
   import dma_irq_bank_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter int NUM_MST = 3,
   parameter int CHAN_FW = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         ev_term,
   input  logic [NUM_CH-1:0]         ev_pend,
   input  logic [NUM_CH-1:0]         ev_lowm,
   input  logic [NUM_CH-1:0]         ev_under,
   input  logic [NUM_CH-1:0]         ev_over,
   input  logic [NUM_CH-1:0]         ev_cherr,
   input  logic [NUM_MST-1:0]        ev_merr,
   input  logic [NUM_MST*CHAN_FW-1:0] merr_chan,
   input  logic [NUM_CH-1:0]         ch_enabled,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   output logic                      irq_o
);
   localparam int NCLS = 3;
   localparam int NRAW = 2;
   localparam logic [DATA_W-1:0] CH_MASK = low_ones(NUM_CH);
   localparam logic [DATA_W-1:0] MS_MASK = low_ones(NUM_MST);

   // elaboration checks
   if (NUM_CH < 1 || NUM_CH > HALF) begin : g_bad_ch
      $error("NUM_CH must be 1..16");
   end
   if (NUM_MST < 1 || NUM_MST * CHAN_FW > DATA_W || NUM_MST > HALF) begin : g_bad_mst
      $error("NUM_MST does not fit the record or raw word");
   end
   if ((1 << CHAN_FW) < NUM_CH) begin : g_bad_fw
      $error("CHAN_FW too narrow for NUM_CH");
   end

   // per-class status words
   logic [NUM_CH-1:0] cls_ev [NCLS];
   logic [NUM_CH-1:0] cls_q  [NCLS];

   always_comb begin
      cls_ev[0] = ev_term;
      cls_ev[1] = ev_pend;
      cls_ev[2] = ev_lowm;
   end

   for (genvar k = 0; k < NCLS; k++) begin : g_cls
      irqb_flag_word #(.W(NUM_CH)) u_word (
         .clk      (clk),
         .rst_n    (rst_n),
         .ev_i     (cls_ev[k]),
         .clr_we_i (reg_wr && reg_addr == ADDR_W'(CLS_STRIDE * k + 1)),
         .set_we_i (reg_wr && reg_addr == ADDR_W'(CLS_STRIDE * k + 2)),
         .wdata_i  (reg_wdata[NUM_CH-1:0]),
         .keep_i   ({NUM_CH{1'b1}}),
         .q_o      (cls_q[k])
      );
   end

   // packed raw words with enable
   logic [DATA_W-1:0] raw_ev   [NRAW];
   logic [DATA_W-1:0] raw_keep [NRAW];
   logic [DATA_W-1:0] raw_q    [NRAW];
   logic [DATA_W-1:0] en_q     [NRAW];

   always_comb begin
      raw_ev[0] = '0;
      raw_ev[1] = '0;
      raw_ev[0][NUM_CH-1:0]       = ev_under;
      raw_ev[0][HALF +: NUM_CH]   = ev_over;
      raw_ev[1][NUM_CH-1:0]       = ev_cherr;
      raw_ev[1][HALF +: NUM_MST]  = ev_merr;
      raw_keep[0] = CH_MASK | (CH_MASK << HALF);
      raw_keep[1] = CH_MASK | (MS_MASK << HALF);
   end

   for (genvar j = 0; j < NRAW; j++) begin : g_raw
      localparam int BASE = RAW_BASE + RAW_STRIDE * j;
      irqb_flag_word #(.W(DATA_W)) u_word (
         .clk      (clk),
         .rst_n    (rst_n),
         .ev_i     (raw_ev[j]),
         .clr_we_i (reg_wr && reg_addr == ADDR_W'(BASE + 3)),
         .set_we_i (reg_wr && reg_addr == ADDR_W'(BASE + 4)),
         .wdata_i  (reg_wdata),
         .keep_i   (raw_keep[j]),
         .q_o      (raw_q[j])
      );
      always_ff @(posedge clk) begin
         if (!rst_n)
            en_q[j] <= '0;
         else if (reg_wr && reg_addr == ADDR_W'(BASE + 1))
            en_q[j] <= reg_wdata & raw_keep[j];
      end
   end

   // master error record
   logic [NUM_MST*CHAN_FW-1:0] merr_info;

   irqb_merr_rec #(.NM(NUM_MST), .FW(CHAN_FW)) u_merr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (ev_merr),
      .chan_i (merr_chan),
      .info_o (merr_info)
   );

   // free-channel scan
   logic [FREE_W-1:0] free_idx;

   irqb_free_scan #(.N(NUM_CH), .IW(FREE_W)) u_free (
      .en_i  (ch_enabled),
      .idx_o (free_idx)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr_e'(reg_addr))
         A_TC_STAT: reg_rdata = DATA_W'(cls_q[0]);
         A_PC_STAT: reg_rdata = DATA_W'(cls_q[1]);
         A_LW_STAT: reg_rdata = DATA_W'(cls_q[2]);
         A_R0_RAW:  reg_rdata = raw_q[0];
         A_R0_EN:   reg_rdata = en_q[0];
         A_R0_MSK:  reg_rdata = raw_q[0] & en_q[0];
         A_R1_RAW:  reg_rdata = raw_q[1];
         A_R1_EN:   reg_rdata = en_q[1];
         A_R1_MSK:  reg_rdata = raw_q[1] & en_q[1];
         A_MERR:    reg_rdata = DATA_W'(merr_info);
         A_FREE:    reg_rdata = {HALF'(ch_enabled), (HALF - FREE_W)'(0), free_idx};
         default:   reg_rdata = '0;
      endcase
   end

   // combined interrupt, one register stage
   logic any_pending;

   always_comb begin
      any_pending = (|(raw_q[0] & en_q[0])) | (|(raw_q[1] & en_q[1]));
      for (int k = 0; k < NCLS; k++) any_pending = any_pending | (|cls_q[k]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= any_pending;
   end
endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk
   import dma_irq_bank_pkg::*;
#(
   parameter int NUM_CH = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_CH-1:0]   ev_term,
   input logic                reg_wr,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic                irq_o,
   input logic [NUM_CH-1:0]   tc_q,
   input logic [NUM_CH-1:0]   pc_q,
   input logic [NUM_CH-1:0]   lw_q,
   input logic [DATA_W-1:0]   raw0_q,
   input logic [DATA_W-1:0]   en0_q,
   input logic [DATA_W-1:0]   raw1_q,
   input logic [DATA_W-1:0]   en1_q,
   input logic [FREE_W-1:0]   free_idx,
   input logic [NUM_CH-1:0]   ch_enabled
);
   logic state_any;
   assign state_any = (|tc_q) | (|pc_q) | (|lw_q) |
                      (|(raw0_q & en0_q)) | (|(raw1_q & en1_q));

   // R2 and R5: a pulsed bit is set on the next edge, clear or not
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_term) |=> ((tc_q & $past(ev_term)) == $past(ev_term)));

   // R3: cleared bits without a concurrent event are gone
   a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_TC_CLR) |=>
      ((tc_q & $past(reg_wdata[NUM_CH-1:0] & ~ev_term)) == '0));

   // R12: a write to the status address leaves the word alone
   a_r12_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_TC_STAT && ev_term == '0) |=> $stable(tc_q));

   // R11: the interrupt follows the pending state by one clock
   a_r11_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(state_any)));

   // R10: the reported free channel is idle
   a_r10_free_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (free_idx < FREE_W'(NUM_CH)) |->
      (((ch_enabled >> free_idx) & NUM_CH'(1)) == '0));

   // R10: all enabled reports the channel count
   a_r10_full_marker: assert property (@(posedge clk) disable iff (!rst_n)
      (&ch_enabled) |-> (free_idx == FREE_W'(NUM_CH)));
endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_term    (ev_term),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .irq_o      (irq_o),
   .tc_q       (cls_q[0]),
   .pc_q       (cls_q[1]),
   .lw_q       (cls_q[2]),
   .raw0_q     (raw_q[0]),
   .en0_q      (en_q[0]),
   .raw1_q     (raw_q[1]),
   .en1_q      (en_q[1]),
   .free_idx   (free_idx),
   .ch_enabled (ch_enabled)
);

// File: tb/sim_dma_irq_bank.sv
module sim_dma_irq_bank;
   import dma_irq_bank_pkg::*;

   localparam int NCH = 16;
   localparam int NM  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] ev_term = '0, ev_pend = '0, ev_lowm = '0;
   logic [NCH-1:0] ev_under = '0, ev_over = '0, ev_cherr = '0;
   logic [NM-1:0]  ev_merr = '0;
   logic [NM*4-1:0] merr_chan = '0;
   logic [NCH-1:0] ch_enabled = '0;
   logic           reg_wr = 1'b0;
   logic [4:0]     reg_addr = '0;
   logic [31:0]    reg_wdata = '0;
   logic [31:0]    reg_rdata;
   logic           irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dma_irq_bank u0 (
      .clk(clk), .rst_n(rst_n), .ev_term(ev_term), .ev_pend(ev_pend),
      .ev_lowm(ev_lowm), .ev_under(ev_under), .ev_over(ev_over),
      .ev_cherr(ev_cherr), .ev_merr(ev_merr), .merr_chan(merr_chan),
      .ch_enabled(ch_enabled), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic pulse_cls(input int k, input logic [NCH-1:0] bits);
      @(negedge clk);
      if (k == 0) ev_term = bits; else if (k == 1) ev_pend = bits; else ev_lowm = bits;
      @(negedge clk);
      ev_term = '0; ev_pend = '0; ev_lowm = '0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] exp;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every readable word
      for (int a = 0; a <= 20; a++) begin
         rd(5'(a), v);
         check("R1 reset read", v, 32'h0);
      end
      check("R1 reset irq", 32'(irq_o), 32'h0);

      // R2 R3 R11: single-channel sweep of every class
      for (int k = 0; k < 3; k++) begin
         for (int ch = 0; ch < NCH; ch++) begin
            pulse_cls(k, NCH'(1) << ch);
            rd(5'(3 * k), v);
            check("R2 class status", v, 32'(1) << ch);
            check("R11 irq still low", 32'(irq_o), 32'h0);
            @(negedge clk);
            check("R11 irq raised", 32'(irq_o), 32'h1);
            wr(5'(3 * k + 1), 32'(1) << ch);
            rd(5'(3 * k), v);
            check("R3 class clear", v, 32'h0);
            @(negedge clk);
            check("R11 irq dropped", 32'(irq_o), 32'h0);
         end
      end

      // R4 R3: set pattern, partial clear
      wr(A_PC_SET, 32'h0000_A5A5);
      rd(A_PC_STAT, v);
      check("R4 set word", v, 32'h0000_A5A5);
      wr(A_PC_CLR, 32'h0000_00FF);
      rd(A_PC_STAT, v);
      check("R3 partial clear", v, 32'h0000_A500);
      wr(A_PC_CLR, 32'hFFFF_FFFF);

      // R5: event and clear in the same cycle
      wr(A_TC_SET, 32'h10);
      @(negedge clk);
      ev_term = NCH'(1) << 3;
      reg_wr = 1'b1; reg_addr = A_TC_CLR; reg_wdata = 32'h18;
      @(negedge clk);
      ev_term = '0; reg_wr = 1'b0; reg_wdata = '0;
      rd(A_TC_STAT, v);
      check("R5 event wins over clear", v, 32'h08);
      wr(A_TC_CLR, 32'hFFFF);

      // R6 R8: raw word 0 mirrored sweep
      for (int ch = 0; ch < NCH; ch++) begin
         @(negedge clk);
         ev_under = NCH'(1) << ch;
         ev_over  = NCH'(1) << (NCH - 1 - ch);
         @(negedge clk);
         ev_under = '0; ev_over = '0;
         rd(A_R0_RAW, v);
         exp = (32'(1) << ch) | (32'(1) << (16 + NCH - 1 - ch));
         check("R6 raw0 layout", v, exp);
         wr(A_R0_CLR, 32'hFFFF_FFFF);
         rd(A_R0_RAW, v);
         check("R8 raw0 clear", v, 32'h0);
      end

      // R6 R9: raw word 1 and master records
      for (int m = 0; m < NM; m++) begin
         @(negedge clk);
         ev_merr = NM'(1) << m;
         ev_cherr = NCH'(1) << (m + 5);
         merr_chan[m*4 +: 4] = 4'((m * 5 + 3) % 16);
         @(negedge clk);
         ev_merr = '0; ev_cherr = '0;
      end
      rd(A_R1_RAW, v);
      check("R6 raw1 layout", v, 32'h0007_00E0);
      rd(A_MERR, v);
      check("R9 master record", v, 32'h0000_0D83);
      @(negedge clk);
      merr_chan[4 +: 4] = 4'hB; ev_merr = 3'b010;
      @(negedge clk);
      ev_merr = '0;
      rd(A_MERR, v);
      check("R9 record overwrite", v, 32'h0000_0DB3);
      wr(A_R1_CLR, 32'h0002_0020);
      rd(A_R1_RAW, v);
      check("R8 raw1 partial clear", v, 32'h0005_00C0);
      wr(A_R1_CLR, 32'hFFFF_FFFF);

      // R7 R11: enable masking
      wr(A_R0_SET, 32'hFFFF_FFFF);
      rd(A_R0_RAW, v);
      check("R8 raw0 set", v, 32'hFFFF_FFFF);
      @(negedge clk);
      check("R11 irq masked off", 32'(irq_o), 32'h0);
      wr(A_R0_EN, 32'h0F0F_00F0);
      rd(A_R0_EN, v);
      check("R7 enable readback", v, 32'h0F0F_00F0);
      rd(A_R0_MSK, v);
      check("R7 masked view", v, 32'h0F0F_00F0);
      check("R11 irq one clock late", 32'(irq_o), 32'h0);
      @(negedge clk);
      check("R11 irq from masked", 32'(irq_o), 32'h1);
      wr(A_R0_CLR, 32'h0F0F_0000);
      rd(A_R0_MSK, v);
      check("R7 masked after clear", v, 32'h0000_00F0);
      wr(A_R1_SET, 32'hFFFF_FFFF);
      rd(A_R1_RAW, v);
      check("R6 raw1 unused bits zero", v, 32'h0007_FFFF);
      rd(A_R1_MSK, v);
      check("R7 raw1 masked disabled", v, 32'h0);

      // R12: read-only addresses ignore writes
      wr(A_TC_STAT, 32'hFFFF_FFFF);
      rd(A_TC_STAT, v);
      check("R12 status write ignored", v, 32'h0);
      wr(A_R0_RAW, 32'h0);
      rd(A_R0_RAW, v);
      check("R12 raw write ignored", v, 32'hF0F0_FFFF);
      wr(A_R0_MSK, 32'h0);
      rd(A_R0_EN, v);
      check("R12 masked write ignored", v, 32'h0F0F_00F0);
      wr(A_MERR, 32'h0);
      rd(A_MERR, v);
      check("R12 record write ignored", v, 32'h0000_0DB3);

      // R10: free-channel scan over prefixes and holes
      for (int k = 0; k <= NCH; k++) begin
         ch_enabled = NCH'((32'(1) << k) - 1);
         rd(A_FREE, v);
         check("R10 prefix scan", v, {16'(ch_enabled), 16'(k)});
      end
      for (int h = 0; h < NCH; h++) begin
         ch_enabled = ~(NCH'(1) << h) & ~(NCH'(1) << ((h + 7) % NCH));
         exp = {16'(ch_enabled), 16'((h < (h + 7) % NCH) ? h : (h + 7) % NCH)};
         rd(A_FREE, v);
         check("R10 holes scan", v, exp);
      end
      wr(A_FREE, 32'h0);
      rd(A_FREE, v);
      check("R12 free write ignored", v, exp);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule